// File: doc/BRIEF.md
# Memory-mapped UART register front-end

This block is the software-facing register shell of a simple serial port. A bus master talks to it through a request/acknowledge slave port that decodes a 32-byte window of word registers. Writing the transmit data word hands its low byte to a byte-stream valid/ready output. The bit-level serializer sits beyond that output. Bytes coming back on a byte-stream input land in an eight-entry receive queue, which software drains by reading the receive data word. The baud divisor and the two control words are plain storage for neighbouring logic. They are kept and reported back, not interpreted. One level interrupt tells the processor that received bytes are waiting.

A single sequencer, `urf_bus_fsm`, serves each request. It has three states. **ST_IDLE** waits for `bus_req`. From there it moves to **ST_TX_WAIT** on a legal transmit-data write, and to **ST_RESPOND** on any other request, legal or not. **ST_TX_WAIT** holds `tx_valid` high until `tx_ready` is seen, then moves to **ST_RESPOND**. **ST_RESPOND** raises `bus_ack` for exactly one cycle, with `bus_err` beside it for a rejected access, and returns to **ST_IDLE**. The master holds its request fields steady until it sees `bus_ack`, then drops `bus_req`.

Register map (byte offsets):
- 0x00 transmit data
- 0x04 receive data
- 0x08 transmit control
- 0x0C receive control
- 0x10 interrupt enable
- 0x14 interrupt pending
- 0x18 divisor
- 0x1C unused hole

In both the enable and pending words, bit 1 is the receive flag and bit 0 is the transmit flag. `bus_size` uses 0 for a byte, 1 for a halfword and 2 for a word; 3 is reserved.

Top module: `uart_mmio_regs`

## Requirements
- R1: Writes to offsets 0x08, 0x0C, 0x10 and 0x18 store all 32 bits, and a later read of the same offset returns that value unchanged.
- R2: An access is legal only when `bus_size` is 2 and `bus_addr[1:0]` is 0. Any other access is answered with `bus_err` high and read data 0, and it changes no register and no queue entry.
- R3: The receive queue holds at most 8 bytes and returns them oldest first. `rx_ready` is low exactly while 8 bytes are held.
- R4: Reading offset 0x04 with a non-empty queue returns the oldest byte in bits 7:0 with all other bits 0, and removes that byte.
- R5: Reading offset 0x04 with an empty queue returns 0x80000000 and changes no state.
- R6: Reading offset 0x14 returns bit 1 set exactly when the queue is non-empty, and all other bits 0. Writes to 0x14 and 0x04 are ignored.
- R7: `irq` is high exactly when enable bit 1 is set and the queue holds at least one byte, following every push, pop and enable write on the next cycle.
- R8: A byte offered on `rx_valid` while the queue is full is discarded, and `rx_overflow` rises and stays high until reset.
- R9: A write to offset 0x00 emits `bus_wdata[7:0]` exactly once on the transmit stream. A read of offset 0x00 returns 0.
- R10: While the transmit stream is not ready, a transmit-data write stays pending. `tx_valid` and `tx_data` hold steady and `bus_ack` stays low until the byte is taken.
- R11: An access to offset 0x1C reads 0, is ignored when writing, and receives a one-cycle `bus_err` with its acknowledge.
- R12: A synchronous reset (`rst_n` low at a clock edge) zeroes every register, empties the queue and clears `rx_overflow`.
- R13: Every request receives exactly one acknowledge, which lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_size | input | 2 | Access size code (2 = word) |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_err | output | 1 | Access rejected, valid with `bus_ack` |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink accepts |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue has space |
| rx_overflow | output | 1 | Sticky: a byte was discarded |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a receive-data pop that lands in the same clock as an arriving byte. With 8 bytes held, the arriving byte must be discarded, because readiness is judged before the pop. With 7 bytes held, both the pop and the push must take effect. The bench drives `rx_valid` and the read request on the same falling edge, once with the queue full and once with one slot free. Its queue model decides acceptance from the size before the pop. A second hard case is the stalled transmit write: the bench holds `tx_ready` low for several cycles while the write is pending, and checks that `tx_valid`, `tx_data` and the missing acknowledge all hold.

// File: rtl/urf_pkg.sv
package urf_pkg;

    localparam int unsigned WIN_ADDR_W = 5;
    localparam logic [1:0]  SIZE_WORD  = 2'd2;
    localparam int unsigned IE_TX_BIT  = 0;
    localparam int unsigned IE_RX_BIT  = 1;

    typedef enum logic [2:0] {
        RID_TXDATA,
        RID_RXDATA,
        RID_TXCTRL,
        RID_RXCTRL,
        RID_IE,
        RID_IP,
        RID_DIV,
        RID_HOLE
    } reg_id_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TX_WAIT,
        ST_RESPOND
    } bus_state_e;

    // Word index inside the window selects the register.
    function automatic reg_id_e decode_offset(input logic [WIN_ADDR_W-1:0] ofs);
        reg_id_e id;
        unique case (ofs[WIN_ADDR_W-1:2])
            3'd0:    id = RID_TXDATA;
            3'd1:    id = RID_RXDATA;
            3'd2:    id = RID_TXCTRL;
            3'd3:    id = RID_RXCTRL;
            3'd4:    id = RID_IE;
            3'd5:    id = RID_IP;
            3'd6:    id = RID_DIV;
            default: id = RID_HOLE;
        endcase
        return id;
    endfunction

endpackage

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty,
    output logic         overflow
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             do_push, do_pop;

    assign in_ready = (count_q != CNT_FULL);
    assign nonempty = (count_q != '0);
    assign head     = mem_q[rd_ptr_q];
    assign overflow = ovf_q;
    assign do_push  = in_valid && in_ready;
    assign do_pop   = pop && nonempty;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wr_ptr_nx = wr_ptr_q + 1'b1;
            assign rd_ptr_nx = rd_ptr_q + 1'b1;
        end else begin : g_cmp_wrap
            assign wr_ptr_nx = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            assign rd_ptr_nx = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_ptr_q] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_nx;
            if (do_pop)  rd_ptr_q <= rd_ptr_nx;
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (in_valid && !in_ready) ovf_q <= 1'b1;
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_FULL);
    p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !pop) |=> (count_q == $past(count_q) + 1'b1));
    p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> overflow);
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    p_empty_pop_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !nonempty && !in_valid) |=> (count_q == '0));

endmodule

// File: rtl/urf_csr_bank.sv
module urf_csr_bank
    import urf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_id_e           id,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic              rx_nonempty,
    output logic              irq
);
    localparam int unsigned NUM_RW   = 4;
    localparam int unsigned SLOT_W   = $clog2(NUM_RW);
    localparam logic [DATA_W-1:0] EMPTY_FLAG = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] store_q [NUM_RW];
    logic [SLOT_W-1:0] slot;
    logic              slot_hit;

    // Storage slots: 0 transmit control, 1 receive control, 2 enable, 3 divisor.
    always_comb begin
        slot_hit = 1'b1;
        unique case (id)
            RID_TXCTRL: slot = SLOT_W'(0);
            RID_RXCTRL: slot = SLOT_W'(1);
            RID_IE:     slot = SLOT_W'(2);
            RID_DIV:    slot = SLOT_W'(3);
            default: begin
                slot     = '0;
                slot_hit = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_RW; k++) store_q[k] <= '0;
        end else if (wr_en && slot_hit) begin
            store_q[slot] <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (id)
            RID_RXDATA: rd_data = rx_nonempty ? DATA_W'(rx_head) : EMPTY_FLAG;
            RID_IP:     rd_data = DATA_W'(rx_nonempty) << IE_RX_BIT;
            RID_TXCTRL, RID_RXCTRL, RID_IE, RID_DIV: rd_data = store_q[slot];
            default:    rd_data = '0;
        endcase
    end

    assign irq = store_q[2][IE_RX_BIT] && rx_nonempty;

    p_irq_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_nonempty);
    p_ie_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store_q[2]));

endmodule

// File: rtl/urf_bus_fsm.sv
module urf_bus_fsm
    import urf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [BYTE_W-1:0]     tx_byte_in,
    output logic                  bus_ack,
    output logic                  bus_err,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  tx_valid,
    output logic [BYTE_W-1:0]     tx_data,
    input  logic                  tx_ready,
    output logic                  csr_wr_en,
    output reg_id_e               csr_id,
    input  logic [DATA_W-1:0]     csr_rdata,
    input  logic                  rx_nonempty,
    output logic                  rx_pop
);
    bus_state_e        state_q, state_d;
    logic              bad, accept;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;
    logic [BYTE_W-1:0] tx_q;

    assign csr_id = decode_offset(bus_addr);
    assign bad    = (bus_size != SIZE_WORD) || (bus_addr[1:0] != 2'b00) ||
                    (csr_id == RID_HOLE);
    assign accept = (state_q == ST_IDLE) && bus_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req) begin
                    if (!bad && bus_we && csr_id == RID_TXDATA) state_d = ST_TX_WAIT;
                    else                                         state_d = ST_RESPOND;
                end
            end
            ST_TX_WAIT: if (tx_ready) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
            tx_q    <= '0;
        end else if (accept) begin
            err_q   <= bad;
            rdata_q <= (bad || bus_we) ? '0 : csr_rdata;
            if (!bad && bus_we && csr_id == RID_TXDATA) tx_q <= tx_byte_in;
        end
    end

    always_comb begin
        csr_wr_en = accept && !bad && bus_we;
        rx_pop    = accept && !bad && !bus_we && (csr_id == RID_RXDATA) && rx_nonempty;
        tx_valid  = (state_q == ST_TX_WAIT);
        tx_data   = tx_q;
        bus_ack   = (state_q == ST_RESPOND);
        bus_err   = bus_ack && err_q;
        bus_rdata = bus_ack ? rdata_q : '0;
    end

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && !bus_ack));
    p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    p_err_has_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);
    p_err_zero_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

endmodule

// File: rtl/uart_mmio_regs.sv
module uart_mmio_regs
    import urf_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned RX_DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_ack,
    output logic                  bus_err,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  tx_valid,
    output logic [BYTE_W-1:0]     tx_data,
    input  logic                  tx_ready,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_data,
    output logic                  rx_ready,
    output logic                  rx_overflow,
    output logic                  irq
);
    logic              csr_wr_en;
    reg_id_e           csr_id;
    logic [DATA_W-1:0] csr_rdata;
    logic              rx_pop, rx_nonempty;
    logic [BYTE_W-1:0] rx_head;

    urf_bus_fsm #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .tx_byte_in (bus_wdata[BYTE_W-1:0]),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .csr_wr_en  (csr_wr_en),
        .csr_id     (csr_id),
        .csr_rdata  (csr_rdata),
        .rx_nonempty(rx_nonempty),
        .rx_pop     (rx_pop)
    );

    urf_csr_bank #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (csr_wr_en),
        .id         (csr_id),
        .wdata      (bus_wdata),
        .rd_data    (csr_rdata),
        .rx_head    (rx_head),
        .rx_nonempty(rx_nonempty),
        .irq        (irq)
    );

    urf_rx_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(rx_valid),
        .in_data (rx_data),
        .in_ready(rx_ready),
        .pop     (rx_pop),
        .head    (rx_head),
        .nonempty(rx_nonempty),
        .overflow(rx_overflow)
    );

    p_pop_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_req && !bus_we));
    p_tx_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(bus_req && bus_we));

endmodule

// File: tb/uart_mmio_regs_tb.sv
module uart_mmio_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, rx_overflow, irq;

    int checks = 0;
    int failures = 0;

    // behavioural model
    logic [7:0]  m_q[$];
    logic [31:0] m_txctrl, m_rxctrl, m_ie, m_div;
    logic        m_ovf;
    logic [7:0]  tx_log[$];
    bit          cmp_en = 1'b0;

    always #2 clk = ~clk;

    uart_mmio_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_overflow(rx_overflow), .irq(irq)
    );

    function automatic void check(input bit ok, input string tag,
                                  input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic void model_reset();
        m_q.delete();
        m_txctrl = '0; m_rxctrl = '0; m_ie = '0; m_div = '0; m_ovf = 1'b0;
    endfunction

    // Applies one accepted access to the model, returns expected data and error.
    function automatic void model_access(input logic we, input logic [4:0] a,
                                         input logic [1:0] sz, input logic [31:0] wd,
                                         output logic [31:0] exp_rd, output logic exp_err);
        bit legal = (sz == 2'd2) && (a[1:0] == 2'b00) && (a != 5'h1C);
        exp_rd = '0;
        exp_err = !legal;
        if (!legal) return;
        if (we) begin
            case (a)
                5'h08: m_txctrl = wd;
                5'h0C: m_rxctrl = wd;
                5'h10: m_ie = wd;
                5'h18: m_div = wd;
                default: ;
            endcase
        end else begin
            case (a)
                5'h04: if (m_q.size() > 0) exp_rd = {24'h0, m_q.pop_front()};
                       else exp_rd = 32'h8000_0000;
                5'h08: exp_rd = m_txctrl;
                5'h0C: exp_rd = m_rxctrl;
                5'h10: exp_rd = m_ie;
                5'h14: exp_rd = {30'h0, (m_q.size() > 0), 1'b0};
                5'h18: exp_rd = m_div;
                default: exp_rd = '0;
            endcase
        end
    endfunction

    // per-clock comparison of the status outputs
    always @(negedge clk) begin
        if (cmp_en) begin
            check(rx_ready == (m_q.size() < 8), "R3 rx_ready", {31'h0, rx_ready}, {31'h0, (m_q.size() < 8)});
            check(irq == (m_ie[1] && m_q.size() > 0), "R7 irq", {31'h0, irq}, {31'h0, (m_ie[1] && m_q.size() > 0)});
            check(rx_overflow == m_ovf, "R8 rx_overflow", {31'h0, rx_overflow}, {31'h0, m_ovf});
        end
    end

    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) tx_log.push_back(tx_data);
    end

    task automatic wait_ack(input string tag, output logic [31:0] rd, output logic er,
                            output int lat);
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (bus_ack || lat > 1000) break;
        end
        check(bus_ack, {tag, " R13 ack seen"}, {31'h0, bus_ack}, 32'h1);
        rd = bus_rdata;
        er = bus_err;
        bus_req = 1'b0;
        @(negedge clk);
        check(!bus_ack, {tag, " R13 ack one cycle"}, {31'h0, bus_ack}, 32'h0);
    endtask

    task automatic bus_op(input logic we, input logic [4:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag, output int lat);
        logic [31:0] exp_rd, rd;
        logic        exp_err, er;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(posedge clk); #1;
        model_access(we, a, sz, wd, exp_rd, exp_err);
        wait_ack(tag, rd, er, lat);
        check(rd == exp_rd, {tag, " rdata"}, rd, exp_rd);
        check(er == exp_err, {tag, " err"}, {31'h0, er}, {31'h0, exp_err});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v, input string tag);
        int lat;
        bus_op(1'b1, a, 2'd2, v, tag, lat);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        int lat;
        bus_op(1'b0, a, 2'd2, 32'h0, tag, lat);
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        if (m_q.size() < 8) m_q.push_back(b); else m_ovf = 1'b1;
        rx_valid = 1'b0;
    endtask

    // receive-data read and a byte arrival in the same clock
    task automatic pop_with_push(input logic [7:0] b, input string tag);
        logic [31:0] exp_rd, rdv;
        logic        exp_err, er;
        int          pre, lat;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 5'h04; bus_size = 2'd2;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        pre = m_q.size();
        model_access(1'b0, 5'h04, 2'd2, 32'h0, exp_rd, exp_err);
        if (pre < 8) m_q.push_back(b); else m_ovf = 1'b1;
        rx_valid = 1'b0;
        wait_ack(tag, rdv, er, lat);
        check(rdv == exp_rd, {tag, " rdata"}, rdv, exp_rd);
    endtask

    task automatic do_reset();
        cmp_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
    endtask

    task automatic dump_regs(input string tag);
        rd(5'h08, tag); rd(5'h0C, tag); rd(5'h10, tag); rd(5'h18, tag); rd(5'h14, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int lat;
        model_reset();
        do_reset();
        // R12 reset state
        check(!bus_ack && !tx_valid && rx_ready && !irq && !rx_overflow, "R12 reset outputs",
              {27'h0, bus_ack, tx_valid, rx_ready, irq, rx_overflow}, 32'h4);
        dump_regs("R12 regs after reset");
        rd(5'h04, "R5 empty read after reset");

        // R1 full-width storage
        wr(5'h08, 32'hDEAD_BEEF, "R1 wr txctrl");
        wr(5'h0C, 32'h1234_5678, "R1 wr rxctrl");
        wr(5'h10, 32'hA5A5_A5A4, "R1 wr ie");
        wr(5'h18, 32'h0001_0F0F, "R1 wr div");
        dump_regs("R1 readback");

        // R9 transmit path
        tx_log.delete();
        wr(5'h00, 32'h1234_56C3, "R9 tx write");
        check(tx_log.size() == 1, "R9 one byte sent", tx_log.size(), 1);
        if (tx_log.size() > 0) check(tx_log[0] == 8'hC3, "R9 byte value", {24'h0, tx_log[0]}, 32'hC3);
        rd(5'h00, "R9 tx read zero");

        // R5, R6 empty queue
        rd(5'h04, "R5 empty read");
        rd(5'h14, "R6 pending empty");
        wr(5'h14, 32'hFFFF_FFFF, "R6 pending write ignored");
        wr(5'h04, 32'hFFFF_FFFF, "R6 rx write ignored");
        rd(5'h14, "R6 pending still empty");

        // R4, R6, R7 data flow
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
        rd(5'h14, "R6 pending set");
        wr(5'h10, 32'h0000_0002, "R7 enable rx irq");
        @(negedge clk);
        check(irq == 1'b1, "R7 irq high", {31'h0, irq}, 32'h1);
        rd(5'h04, "R4 pop 1"); rd(5'h04, "R4 pop 2"); rd(5'h04, "R4 pop 3");
        check(irq == 1'b0, "R7 irq low after drain", {31'h0, irq}, 32'h0);
        rd(5'h04, "R5 empty again");

        // R3, R8 fill and overflow
        for (int i = 0; i < 8; i++) push_byte(8'hA0 + 8'(i));
        @(negedge clk);
        check(rx_ready == 1'b0, "R3 full not ready", {31'h0, rx_ready}, 32'h0);
        push_byte(8'hEE);
        @(negedge clk);
        check(rx_overflow == 1'b1, "R8 overflow set", {31'h0, rx_overflow}, 32'h1);
        // simultaneous pop and push: full then one free
        pop_with_push(8'h5A, "R3 pop+push when full");
        pop_with_push(8'h6B, "R3 pop+push with space");
        for (int i = 0; i < 8; i++) rd(5'h04, "R3 fifo order");
        rd(5'h04, "R5 empty after drain");
        check(rx_overflow == 1'b1, "R8 overflow sticky", {31'h0, rx_overflow}, 32'h1);

        // R2, R11 illegal accesses
        bus_op(1'b0, 5'h18, 2'd0, 32'h0, "R2 byte read", lat);
        bus_op(1'b1, 5'h18, 2'd1, 32'hFFFF_FFFF, "R2 half write", lat);
        bus_op(1'b1, 5'h19, 2'd2, 32'hFFFF_FFFF, "R2 misaligned write", lat);
        push_byte(8'h77);
        bus_op(1'b0, 5'h06, 2'd2, 32'h0, "R2 misaligned rx read", lat);
        bus_op(1'b0, 5'h1C, 2'd2, 32'h0, "R11 hole read", lat);
        bus_op(1'b1, 5'h1C, 2'd2, 32'hFFFF_FFFF, "R11 hole write", lat);
        dump_regs("R11 regs unchanged");
        rd(5'h04, "R2 byte kept");

        // R10 transmit stall
        tx_log.delete();
        tx_ready = 1'b0;
        fork
            begin
                int l;
                bus_op(1'b1, 5'h00, 2'd2, 32'h0000_0099, "R10 stalled write", l);
                check(l > 5, "R10 latency", l, 6);
            end
            begin
                repeat (6) @(negedge clk);
                check(tx_valid && tx_data == 8'h99, "R10 byte held", {23'h0, tx_valid, tx_data}, 32'h199);
                check(!bus_ack, "R10 no ack while stalled", {31'h0, bus_ack}, 32'h0);
                tx_ready = 1'b1;
            end
        join
        check(tx_log.size() == 1, "R10 sent once", tx_log.size(), 1);

        // R12 reset from loaded state
        push_byte(8'h42);
        push_byte(8'h43);
        do_reset();
        check(!rx_overflow && !irq && rx_ready, "R12 status cleared",
              {29'h0, rx_overflow, irq, rx_ready}, 32'h1);
        dump_regs("R12 regs cleared");
        rd(5'h04, "R12 queue empty");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule